// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two eight-bit buses, A and B, through tri-state ports. Each direction has its own storage register, clocked by its own clock and reset: the A-to-B register samples bus A, and the B-to-A register samples bus B. A per-direction select picks what the driven bus receives. Low passes live data from the opposite bus. High passes the stored copy. A per-direction enable decides whether the block drives that bus at all.

When both directions are enabled with live selects, the two buses feed each other and form a loop. The model breaks this loop with a keeper per bus. Each keeper follows the resolved bus value while the loop is open and freezes when the loop closes. The pair then retains its last value with no external driver.

A small decoder turns the four control inputs into a per-direction path (`PATH_OFF`, `PATH_LIVE`, `PATH_STORED`) and a link mode:
- `LINK_OPEN`: neither bus is driven.
- `LINK_A_TO_B`: only B is driven.
- `LINK_B_TO_A`: only A is driven.
- `LINK_CROSS`: both buses are driven and at least one select is high.
- `LINK_HOLD`: both buses are driven and both selects are low.

The link mode changes at once whenever a control input changes. Every combination of the four inputs leads directly to exactly one mode.

Top module: `xcvr_reg_bidir`

## Requirements
- R1: A high `rst_ab` at a rising `clk_ab` clears the A-to-B register to 0x00. A high `rst_ba` at a rising `clk_ba` clears the B-to-A register to 0x00. Each reset acts only on its own register.
- R2: The A-to-B register takes the value on bus A at each rising `clk_ab`. The B-to-A register takes the value on bus B at each rising `clk_ba`. Neither register changes without its own clock edge.
- R3: Register capture happens whatever the values of `sel_ab`, `sel_ba`, `oe_ab` and `oe_ba_n`.
- R4: With B driven, `sel_ab`=0 puts the live bus A value on B, and `sel_ab`=1 puts the A-to-B register on B. With A driven, `sel_ba`=0 puts the live bus B value on A, and `sel_ba`=1 puts the B-to-A register on A.
- R5: `oe_ab`=1 (active high) makes the block drive bus B; `oe_ab`=0 leaves B at high impedance on all bits. `oe_ba_n`=0 (active low) makes the block drive bus A; `oe_ba_n`=1 leaves A at high impedance on all bits.
- R6: Both buses can be driven at once. With both selects high, A carries the B-to-A register and B carries the A-to-B register. With exactly one select high, both buses carry that register.
- R7: With `oe_ab`=1, `oe_ba_n`=0 and both selects low, both buses keep the value they had just before the loop closed. They keep it across any number of edges on either clock.
- R8: When a select input changes, the driven bus moves directly to the newly selected source in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Clock of the A-to-B register |
| rst_ab | input | 1 | Synchronous active-high reset, `clk_ab` domain |
| clk_ba | input | 1 | Clock of the B-to-A register |
| rst_ba | input | 1 | Synchronous active-high reset, `clk_ba` domain |
| oe_ab | input | 1 | Active-high enable for driving bus B |
| oe_ba_n | input | 1 | Active-low enable for driving bus A |
| sel_ab | input | 1 | Source for B: 0 live bus A, 1 stored register |
| sel_ba | input | 1 | Source for A: 0 live bus B, 1 stored register |
| bus_a | inout | 8 | Bus A |
| bus_b | inout | 8 | Bus B |

## Verification
A wrong value captured in a direction register stays hidden until that direction is enabled with its select high. From then on it shows on the driven bus in the same cycle. The bench therefore checks every capture by switching to the stored path later.

A keeper that tracks when it should freeze shows up only once the loop closes and the external drivers are gone. The held value then drifts away from the last resolved value on the first cycle in hold.

A wrong link-mode decode shows at once as a bus taking the wrong source. It can also show as a bus that stays driven while the bench drives it, which the bench sees as a readback mismatch.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int XCVR_W = 8;

    typedef enum logic [1:0] {
        PATH_OFF    = 2'd0,
        PATH_LIVE   = 2'd1,
        PATH_STORED = 2'd2
    } path_e;

    typedef enum logic [2:0] {
        LINK_OPEN   = 3'd0,
        LINK_A_TO_B = 3'd1,
        LINK_B_TO_A = 3'd2,
        LINK_CROSS  = 3'd3,
        LINK_HOLD   = 3'd4
    } link_e;

endpackage

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/xcvr_link_ctrl.sv
module xcvr_link_ctrl
    import xcvr_pkg::*;
(
    input  logic  oe_ab,
    input  logic  oe_ba_n,
    input  logic  sel_ab,
    input  logic  sel_ba,
    output path_e path_ab,
    output path_e path_ba,
    output link_e mode
);

    always_comb begin
        if (!oe_ab) begin
            path_ab = PATH_OFF;
        end else if (sel_ab) begin
            path_ab = PATH_STORED;
        end else begin
            path_ab = PATH_LIVE;
        end

        if (oe_ba_n) begin
            path_ba = PATH_OFF;
        end else if (sel_ba) begin
            path_ba = PATH_STORED;
        end else begin
            path_ba = PATH_LIVE;
        end
    end

    always_comb begin
        unique case ({path_ab != PATH_OFF, path_ba != PATH_OFF})
            2'b00:   mode = LINK_OPEN;
            2'b10:   mode = LINK_A_TO_B;
            2'b01:   mode = LINK_B_TO_A;
            default: mode = (path_ab == PATH_LIVE && path_ba == PATH_LIVE)
                            ? LINK_HOLD : LINK_CROSS;
        endcase
    end

endmodule

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
    parameter int W = 8
) (
    input  logic         hold,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_latch begin
        if (!hold) begin
            q <= d;
        end
    end

endmodule

// File: rtl/xcvr_reg_bidir.sv
module xcvr_reg_bidir
    import xcvr_pkg::*;
#(
    parameter int W = XCVR_W
) (
    input  logic         clk_ab,
    input  logic         rst_ab,
    input  logic         clk_ba,
    input  logic         rst_ba,
    input  logic         oe_ab,
    input  logic         oe_ba_n,
    input  logic         sel_ab,
    input  logic         sel_ba,
    inout  wire  [W-1:0] bus_a,
    inout  wire  [W-1:0] bus_b
);

    path_e        path_ab;
    path_e        path_ba;
    link_e        mode;
    logic [W-1:0] cap_ab_q;
    logic [W-1:0] cap_ba_q;
    logic [W-1:0] a_live;
    logic [W-1:0] b_live;
    logic [W-1:0] keep_a;
    logic [W-1:0] keep_b;
    logic [W-1:0] a_val;
    logic [W-1:0] b_val;
    logic         drive_a;
    logic         drive_b;
    logic         in_hold;

    xcvr_link_ctrl u_ctrl (
        .oe_ab   (oe_ab),
        .oe_ba_n (oe_ba_n),
        .sel_ab  (sel_ab),
        .sel_ba  (sel_ba),
        .path_ab (path_ab),
        .path_ba (path_ba),
        .mode    (mode)
    );

    xcvr_capture #(.W(W)) u_cap_ab (
        .clk (clk_ab),
        .rst (rst_ab),
        .d   (bus_a),
        .q   (cap_ab_q)
    );

    xcvr_capture #(.W(W)) u_cap_ba (
        .clk (clk_ba),
        .rst (rst_ba),
        .d   (bus_b),
        .q   (cap_ba_q)
    );

    // Resolved bus values with the cross loop open; while held they recirculate the keepers.
    always_comb begin
        a_live = bus_a;
        b_live = bus_b;
        unique case (mode)
            LINK_OPEN: begin
                a_live = bus_a;
                b_live = bus_b;
            end
            LINK_A_TO_B: begin
                a_live = bus_a;
                b_live = (path_ab == PATH_STORED) ? cap_ab_q : bus_a;
            end
            LINK_B_TO_A: begin
                b_live = bus_b;
                a_live = (path_ba == PATH_STORED) ? cap_ba_q : bus_b;
            end
            LINK_CROSS: begin
                a_live = (path_ba == PATH_STORED) ? cap_ba_q : cap_ab_q;
                b_live = (path_ab == PATH_STORED) ? cap_ab_q : cap_ba_q;
            end
            LINK_HOLD: begin
                a_live = keep_a;
                b_live = keep_b;
            end
            default: begin
                a_live = bus_a;
                b_live = bus_b;
            end
        endcase
    end

    assign in_hold = (mode == LINK_HOLD);

    xcvr_keeper #(.W(W)) u_keep_a (
        .hold (in_hold),
        .d    (a_live),
        .q    (keep_a)
    );

    xcvr_keeper #(.W(W)) u_keep_b (
        .hold (in_hold),
        .d    (b_live),
        .q    (keep_b)
    );

    assign a_val   = in_hold ? keep_a : a_live;
    assign b_val   = in_hold ? keep_b : b_live;
    assign drive_a = (path_ba != PATH_OFF);
    assign drive_b = (path_ab != PATH_OFF);

    assign bus_a = drive_a ? a_val : {W{1'bz}};
    assign bus_b = drive_b ? b_val : {W{1'bz}};

endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
    parameter int W = 8
) (
    input logic         clk_ab,
    input logic         rst_ab,
    input logic         clk_ba,
    input logic         rst_ba,
    input logic         oe_ab,
    input logic         oe_ba_n,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic [W-1:0] bus_a,
    input logic [W-1:0] bus_b,
    input logic [W-1:0] cap_ab_q,
    input logic [W-1:0] cap_ba_q
);

    logic loop_closed;
    assign loop_closed = oe_ab && !oe_ba_n && !sel_ab && !sel_ba;

    p_capture_r2: assert property (@(posedge clk_ab) disable iff (rst_ab)
        !$past(rst_ab) |-> (cap_ab_q === $past(bus_a)));

    p_stored_b_r4: assert property (@(posedge clk_ab) disable iff (rst_ab)
        (oe_ab && sel_ab) |-> (bus_b === cap_ab_q));

    p_stored_a_r4: assert property (@(posedge clk_ba) disable iff (rst_ba)
        (!oe_ba_n && sel_ba) |-> (bus_a === cap_ba_q));

    p_live_b_r4: assert property (@(posedge clk_ab) disable iff (rst_ab)
        (oe_ab && !sel_ab && oe_ba_n) |-> (bus_b === bus_a));

    p_hold_r7: assert property (@(posedge clk_ab) disable iff (rst_ab)
        (loop_closed && $past(loop_closed)) |->
        (bus_a === $past(bus_a) && bus_b === $past(bus_b)));

endmodule

bind xcvr_reg_bidir xcvr_chk #(.W(W)) u_chk (
    .clk_ab   (clk_ab),
    .rst_ab   (rst_ab),
    .clk_ba   (clk_ba),
    .rst_ba   (rst_ba),
    .oe_ab    (oe_ab),
    .oe_ba_n  (oe_ba_n),
    .sel_ab   (sel_ab),
    .sel_ba   (sel_ba),
    .bus_a    (bus_a),
    .bus_b    (bus_b),
    .cap_ab_q (cap_ab_q),
    .cap_ba_q (cap_ba_q)
);

// File: tb/sim_xcvr_reg_bidir.sv
module sim_xcvr_reg_bidir;

    logic       clk = 1'b0;
    logic       en_ab = 1'b0;
    logic       en_ba = 1'b0;
    logic       rst_ab = 1'b1;
    logic       rst_ba = 1'b1;
    logic       oe_ab = 1'b0;
    logic       oe_ba_n = 1'b1;
    logic       sel_ab = 1'b0;
    logic       sel_ba = 1'b0;
    logic       a_en = 1'b0;
    logic       b_en = 1'b0;
    logic [7:0] a_drv = 8'h00;
    logic [7:0] b_drv = 8'h00;
    wire        clk_ab;
    wire        clk_ba;
    wire  [7:0] bus_a;
    wire  [7:0] bus_b;

    int total = 0;
    int bad = 0;

    // reference state
    logic [7:0] m_ab = 8'h00;
    logic [7:0] m_ba = 8'h00;
    bit         mk_ab = 0;
    bit         mk_ba = 0;
    logic [7:0] last_a = 8'h00;
    logic [7:0] last_b = 8'h00;
    bit         lk_a = 0;
    bit         lk_b = 0;
    logic [7:0] ea;
    logic [7:0] eb;
    bit         ka;
    bit         kb;

    always #2 clk = ~clk;
    assign clk_ab = clk & en_ab;
    assign clk_ba = clk & en_ba;
    assign bus_a = a_en ? a_drv : 8'hzz;
    assign bus_b = b_en ? b_drv : 8'hzz;

    xcvr_reg_bidir u0 (
        .clk_ab  (clk_ab),
        .rst_ab  (rst_ab),
        .clk_ba  (clk_ba),
        .rst_ba  (rst_ba),
        .oe_ab   (oe_ab),
        .oe_ba_n (oe_ba_n),
        .sel_ab  (sel_ab),
        .sel_ba  (sel_ba),
        .bus_a   (bus_a),
        .bus_b   (bus_b)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic resolve();
        bit sa, sb, la, lb;
        ka = 0; kb = 0; ea = 8'h00; eb = 8'h00;
        if (a_en) begin ea = a_drv; ka = 1; end
        if (b_en) begin eb = b_drv; kb = 1; end
        sa = !oe_ba_n && sel_ba;
        sb = oe_ab && sel_ab;
        la = !oe_ba_n && !sel_ba;
        lb = oe_ab && !sel_ab;
        if (sa) begin ea = m_ba; ka = mk_ba; end
        if (sb) begin eb = m_ab; kb = mk_ab; end
        if (la && lb) begin
            ea = last_a; ka = lk_a;
            eb = last_b; kb = lk_b;
        end else begin
            if (lb) begin eb = ea; kb = ka; end
            if (la) begin ea = eb; ka = kb; end
            last_a = ea; lk_a = ka;
            last_b = eb; lk_b = kb;
        end
    endtask

    task automatic compare(input string tag);
        resolve();
        if (ka) chk(tag, bus_a, ea);
        if (kb) chk(tag, bus_b, eb);
    endtask

    // one clock: model update at the edge, comparison 1 ns later, return at falling edge
    task automatic cyc(input string tag);
        @(posedge clk);
        resolve();
        if (en_ab) begin
            m_ab  = rst_ab ? 8'h00 : ea;
            mk_ab = rst_ab ? 1'b1 : ka;
        end
        if (en_ba) begin
            m_ba  = rst_ba ? 8'h00 : eb;
            mk_ba = rst_ba ? 1'b1 : kb;
        end
        #1;
        compare(tag);
        @(negedge clk);
    endtask

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: synchronous reset of both registers
        en_ab = 1; en_ba = 1;
        repeat (2) cyc("R1");
        rst_ab = 0; rst_ba = 0;
        en_ab = 0; en_ba = 0;
        oe_ab = 1; sel_ab = 1; oe_ba_n = 0; sel_ba = 1;
        cyc("R1");
        chk("R1", bus_b, 8'h00);
        chk("R1", bus_a, 8'h00);

        // R5: both directions off, bench drives both buses and reads back its own values
        oe_ab = 0; oe_ba_n = 1; sel_ab = 0; sel_ba = 0;
        a_en = 1; b_en = 1; a_drv = 8'h3C; b_drv = 8'hC3;
        cyc("R5");
        chk("R5", bus_a, 8'h3C);
        chk("R5", bus_b, 8'hC3);

        // R2/R3: capture A-to-B only, with selects low and outputs off
        a_drv = 8'hA5; b_drv = 8'h5A; en_ab = 1;
        cyc("R3");
        en_ab = 0; a_drv = 8'h11; b_drv = 8'h22;
        repeat (2) cyc("R2");
        a_en = 0; b_en = 0;
        oe_ab = 1; sel_ab = 1; oe_ba_n = 0; sel_ba = 1;
        cyc("R2");
        chk("R2", bus_b, 8'hA5);
        chk("R2", bus_a, 8'h00);

        // R3: capture B-to-A with A-side select low and A output off
        oe_ab = 0; oe_ba_n = 1; sel_ab = 1; sel_ba = 0;
        b_en = 1; b_drv = 8'h5A; a_en = 1; a_drv = 8'h99; en_ba = 1;
        cyc("R3");
        en_ba = 0; b_drv = 8'h77;
        cyc("R3");
        a_en = 0; oe_ba_n = 0; sel_ba = 1;
        cyc("R3");
        chk("R3", bus_a, 8'h5A);

        // R4: live paths in each direction with several patterns
        oe_ba_n = 1; b_en = 0; a_en = 1; oe_ab = 1; sel_ab = 0;
        foreach (a_drv[i]) begin
            a_drv = 8'h01 << i;
            cyc("R4");
            chk("R4", bus_b, 8'h01 << i);
        end
        a_drv = 8'hFF; cyc("R4");
        a_drv = 8'h00; cyc("R4");
        oe_ab = 0; a_en = 0; b_en = 1; oe_ba_n = 0; sel_ba = 0;
        b_drv = 8'h81; cyc("R4");
        chk("R4", bus_a, 8'h81);
        b_drv = 8'h7E; cyc("R4");

        // R8: select change moves output directly, no clock edge in between
        oe_ba_n = 1; b_en = 0; a_en = 1; a_drv = 8'h0F; oe_ab = 1; sel_ab = 0;
        cyc("R8");
        #1; sel_ab = 1; #1;
        compare("R8");
        chk("R8", bus_b, 8'hA5);
        #1; sel_ab = 0; #0.5;
        compare("R8");
        chk("R8", bus_b, 8'h0F);
        @(negedge clk);

        // R6: both buses driven from registers
        a_en = 0; oe_ab = 1; sel_ab = 1; oe_ba_n = 0; sel_ba = 1;
        cyc("R6");
        chk("R6", bus_a, 8'h5A);
        chk("R6", bus_b, 8'hA5);
        sel_ba = 0;
        cyc("R6");
        chk("R6", bus_a, 8'hA5);
        sel_ba = 1; sel_ab = 0;
        cyc("R6");
        chk("R6", bus_b, 8'h5A);

        // R7: close the loop from a stored source, keep clocks running
        sel_ba = 0;
        #1;
        compare("R7");
        @(negedge clk);
        en_ab = 1; en_ba = 1;
        repeat (4) begin
            cyc("R7");
            chk("R7", bus_a, 8'h5A);
            chk("R7", bus_b, 8'h5A);
        end
        en_ab = 0; en_ba = 0;
        // leave the loop through the stored path: A-to-B register now holds 0x5A
        sel_ab = 1;
        cyc("R7");
        chk("R7", bus_b, 8'h5A);
        chk("R7", bus_a, 8'h5A);

        // R1: reset of one domain leaves the other register untouched
        oe_ab = 0; oe_ba_n = 1; sel_ab = 1; sel_ba = 1;
        a_en = 1; a_drv = 8'hC6; en_ab = 1;
        cyc("R1");
        en_ab = 0; rst_ba = 1; en_ba = 1;
        b_en = 1; b_drv = 8'hEE;
        cyc("R1");
        rst_ba = 0; en_ba = 0; a_en = 0; b_en = 0;
        oe_ab = 1; oe_ba_n = 0;
        cyc("R1");
        chk("R1", bus_a, 8'h00);
        chk("R1", bus_b, 8'hC6);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule